// File: doc/BRIEF.md
# Consecutive-breach boost frequency controller

This block maintains a boost term that lifts a memory clock request when an activity monitor reports several consecutive watermark breaches. Each run starts with a single-cycle start pulse. The pulse carries the breach flags, the averaged activity count, the current and maximum clock rates in kHz, the sampling period in ms, and the per-source coefficients and thresholds. The block then updates the boost and the two breach-interrupt enables. It recomputes the four watermark values that the monitor compares against, and it produces a target rate. A one-cycle done pulse marks the moment when all outputs are valid.

All products and quotients go through one shared shift-add multiplier and one restoring divider, used one after the other by a step sequencer. Each run takes a few hundred cycles. Every intermediate result of the form value·percent/100 saturates to 2^32−1. A reseed option restarts the boost at zero and derives the average from the current rate instead of taking it from the input.

Top module: `boost_gov`

## Requirements
- R1: A start pulse while idle latches all inputs and raises busy on the next cycle. A start pulse while busy has no effect on the run in progress. done is high for exactly one cycle when the run's outputs are valid, and busy is low in that cycle.
- R2: With flag_up set, boost becomes min(boost·up_coef/100, 2^32−1) + 16000 and en_below becomes 1. If that sum is at or above max_khz, boost is set to max_khz and en_above becomes 0.
- R3: With only flag_dn set, boost becomes boost·dn_coef/100 and en_above becomes 1. If that value is below 8000, boost becomes 0 and en_below becomes 0.
- R4: With both flags set, only the flag_up rule (R2) applies.
- R5: Every value·percent/100 result, and every cur_khz·period product, saturates at 2^32−1 and never wraps.
- R6: band = floor(max_khz·6/1000)·period_ms, saturated to 32 bits. The average upper watermark is avg+band, capped at 2^32−1. The average lower watermark is avg−band, floored at 0.
- R7: With base = cur_khz·period_ms, the upper watermark is base·up_thr/100 and the lower watermark is base·dn_thr/100.
- R8: target = floor(floor(avg/period_ms)·floor(10000/up_thr)/100) + boost, capped at 2^32−1. The boost used here is the value after the update of the same run.
- R9: With reseed set, the flags are not used. boost becomes 0, en_above becomes 1, en_below becomes 0, and the average used by the run is cur_khz·period_ms instead of avg_i.
- R10: After reset: busy 0, done 0, boost 0, en_above 1, en_below 0, and all watermarks and the target are 0.
- R11: With neither flag set and no reseed, the boost and both enables keep their values, and the other outputs are recomputed.
- R12: While idle with no start pulse, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| reseed_i | input | 1 | Restart boost and seed the average from cur_khz·period_ms |
| flag_up_i | input | 1 | Consecutive upper breach reported |
| flag_dn_i | input | 1 | Consecutive lower breach reported |
| avg_i | input | FREQ_W | Averaged activity count |
| cur_khz_i | input | FREQ_W | Current clock rate in kHz |
| max_khz_i | input | FREQ_W | Maximum clock rate in kHz |
| period_ms_i | input | PER_W | Sampling period in ms (1 or more) |
| up_coef_i | input | COEF_W | Boost growth percentage |
| dn_coef_i | input | COEF_W | Boost decay percentage |
| up_thr_i | input | COEF_W | Upper threshold percentage (1 or more) |
| dn_thr_i | input | COEF_W | Lower threshold percentage |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| boost_o | output | FREQ_W | Boost term in kHz |
| en_above_o | output | 1 | Upper consecutive breach interrupt enable |
| en_below_o | output | 1 | Lower consecutive breach interrupt enable |
| wm_up_o | output | FREQ_W | Upper raw watermark |
| wm_lo_o | output | FREQ_W | Lower raw watermark |
| avg_wm_up_o | output | FREQ_W | Upper average watermark |
| avg_wm_lo_o | output | FREQ_W | Lower average watermark |
| target_o | output | FREQ_W | Target rate in kHz |

## Verification
A corrupted boost register does not stay hidden inside the block. It shows up at done as a wrong boost_o, and the same run also shifts target_o by the same amount. The next flagged run then compounds the error through the growth or decay percentage. A wrong step in the sequencer, or a stale intermediate, shows up as a wrong watermark or target at the very next done pulse. A lost enable update shows up at once as both enables low, or as an enable that fails to flip across a clamp or zero cutoff. A start pulse that is wrongly accepted mid-run shows up as outputs of the intruding request at the done pulse of the first run.

// File: rtl/bg_pkg.sv
package bg_pkg;
   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_SEED  = 4'd1,
      ST_BOOST = 4'd2,
      ST_BANDA = 4'd3,
      ST_BAND  = 4'd4,
      ST_BASE  = 4'd5,
      ST_WMUP  = 4'd6,
      ST_WMLO  = 4'd7,
      ST_T1    = 4'd8,
      ST_COEF  = 4'd9,
      ST_TQ    = 4'd10,
      ST_FIN   = 4'd11
   } bg_step_e;
endpackage

// File: rtl/bg_seq_mul.sv
module bg_seq_mul #(
   parameter int AW        = 32,
   parameter int BW        = 16,
   parameter bit EARLY_OUT = 1'b1,
   localparam int PW       = AW + BW,
   localparam int CW       = $clog2(BW + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [AW-1:0] a_i,
   input  logic [BW-1:0] b_i,
   output logic          done_o,
   output logic [PW-1:0] prod_o
);
   logic [PW-1:0] mcand_q, acc_q;
   logic [BW-1:0] mplier_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          last;

   generate
      if (EARLY_OUT) begin : g_early
         assign last = (cnt_q == CW'(1)) || (mplier_q[BW-1:1] == '0);
      end else begin : g_full
         assign last = (cnt_q == CW'(1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mcand_q  <= '0;
         acc_q    <= '0;
         mplier_q <= '0;
         cnt_q    <= '0;
         run_q    <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            mcand_q  <= PW'(a_i);
            mplier_q <= b_i;
            acc_q    <= '0;
            cnt_q    <= CW'(BW);
            run_q    <= 1'b1;
         end else if (run_q) begin
            if (mplier_q[0]) acc_q <= acc_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            cnt_q    <= cnt_q - CW'(1);
            if (last) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign prod_o = acc_q;
endmodule

// File: rtl/bg_seq_div.sv
module bg_seq_div #(
   parameter int NW  = 48,
   parameter int DW  = 16,
   localparam int CW = $clog2(NW + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [NW-1:0] dividend_i,
   input  logic [DW-1:0] divisor_i,
   output logic          done_o,
   output logic [NW-1:0] quo_o
);
   logic [NW-1:0] quo_q;
   logic [DW-1:0] rem_q, dvsr_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [DW:0]   trial, diff;
   logic          ge;

   assign trial = {rem_q, quo_q[NW-1]};
   assign ge    = trial >= {1'b0, dvsr_q};
   assign diff  = trial - {1'b0, dvsr_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         quo_q  <= '0;
         rem_q  <= '0;
         dvsr_q <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            quo_q  <= dividend_i;
            rem_q  <= '0;
            dvsr_q <= divisor_i;
            cnt_q  <= CW'(NW);
            run_q  <= 1'b1;
         end else if (run_q) begin
            rem_q <= ge ? diff[DW-1:0] : trial[DW-1:0];
            quo_q <= {quo_q[NW-2:0], ge};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = quo_q;
endmodule

// File: rtl/boost_gov.sv
module boost_gov
   import bg_pkg::*;
#(
   parameter int FREQ_W      = 32,
   parameter int COEF_W      = 16,
   parameter int PER_W       = 9,
   parameter int STEP_KHZ    = 16000,
   parameter int BAND_PERMIL = 6,
   parameter bit MUL_EARLY   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              reseed_i,
   input  logic              flag_up_i,
   input  logic              flag_dn_i,
   input  logic [FREQ_W-1:0] avg_i,
   input  logic [FREQ_W-1:0] cur_khz_i,
   input  logic [FREQ_W-1:0] max_khz_i,
   input  logic [PER_W-1:0]  period_ms_i,
   input  logic [COEF_W-1:0] up_coef_i,
   input  logic [COEF_W-1:0] dn_coef_i,
   input  logic [COEF_W-1:0] up_thr_i,
   input  logic [COEF_W-1:0] dn_thr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [FREQ_W-1:0] boost_o,
   output logic              en_above_o,
   output logic              en_below_o,
   output logic [FREQ_W-1:0] wm_up_o,
   output logic [FREQ_W-1:0] wm_lo_o,
   output logic [FREQ_W-1:0] avg_wm_up_o,
   output logic [FREQ_W-1:0] avg_wm_lo_o,
   output logic [FREQ_W-1:0] target_o
);
   localparam int QW = FREQ_W + COEF_W;
   localparam logic [FREQ_W-1:0] FMAX  = '1;
   localparam logic [FREQ_W:0]   STEPV = (FREQ_W+1)'(STEP_KHZ);
   localparam logic [FREQ_W-1:0] HALFV = FREQ_W'(STEP_KHZ / 2);

   generate
      if (PER_W > COEF_W || COEF_W < 14 || FREQ_W < 16) begin : g_bad_cfg
         $error("boost_gov: PER_W must fit in COEF_W, COEF_W >= 14, FREQ_W >= 16");
      end
   endgenerate

   bg_step_e            step_q, nxt;
   logic                issue_q, up_q, dn_q;
   logic [FREQ_W-1:0]   cur_q, max_q, avg_q, banda_q, band_q, base_q, t1_q, coef_q, tq_q;
   logic [COEF_W-1:0]   per_q, upc_q, dnc_q, uthr_q, dthr_q;
   logic [FREQ_W-1:0]   op_a, res;
   logic [COEF_W-1:0]   op_b, op_d;
   logic                mul_done, div_done;
   logic [QW-1:0]       prod, quo;
   logic [FREQ_W:0]     up_sum, avg_sum, tgt_sum;

   always_comb begin
      op_a = cur_q; op_b = per_q; op_d = COEF_W'(1);
      unique case (step_q)
         ST_BOOST: begin op_a = boost_o; op_b = up_q ? upc_q : dnc_q; op_d = COEF_W'(100); end
         ST_BANDA: begin op_a = max_q; op_b = COEF_W'(BAND_PERMIL); op_d = COEF_W'(1000); end
         ST_BAND:  begin op_a = banda_q; end
         ST_WMUP:  begin op_a = base_q; op_b = uthr_q; op_d = COEF_W'(100); end
         ST_WMLO:  begin op_a = base_q; op_b = dthr_q; op_d = COEF_W'(100); end
         ST_T1:    begin op_a = avg_q; op_b = COEF_W'(1); op_d = per_q; end
         ST_COEF:  begin op_a = FREQ_W'(10000); op_b = COEF_W'(1); op_d = uthr_q; end
         ST_TQ:    begin op_a = t1_q; op_b = coef_q[COEF_W-1:0]; op_d = COEF_W'(100); end
         default:  ;
      endcase
   end

   bg_seq_mul #(.AW(FREQ_W), .BW(COEF_W), .EARLY_OUT(MUL_EARLY)) u_mul (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(issue_q),
      .a_i(op_a), .b_i(op_b), .done_o(mul_done), .prod_o(prod));

   bg_seq_div #(.NW(QW), .DW(COEF_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mul_done),
      .dividend_i(prod), .divisor_i(op_d), .done_o(div_done), .quo_o(quo));

   assign res     = (|quo[QW-1:FREQ_W]) ? FMAX : quo[FREQ_W-1:0];
   assign up_sum  = {1'b0, res} + STEPV;
   assign avg_sum = {1'b0, avg_q} + {1'b0, band_q};
   assign tgt_sum = {1'b0, tq_q} + {1'b0, boost_o};
   assign nxt     = (step_q == ST_SEED) ? ST_BANDA : bg_step_e'(step_q + 4'd1);
   assign busy_o  = (step_q != ST_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_q <= ST_IDLE; issue_q <= 1'b0; done_o <= 1'b0;
         up_q <= 1'b0; dn_q <= 1'b0;
         cur_q <= '0; max_q <= '0; avg_q <= '0; banda_q <= '0; band_q <= '0;
         base_q <= '0; t1_q <= '0; coef_q <= '0; tq_q <= '0;
         per_q <= '0; upc_q <= '0; dnc_q <= '0; uthr_q <= '0; dthr_q <= '0;
         boost_o <= '0; en_above_o <= 1'b1; en_below_o <= 1'b0;
         wm_up_o <= '0; wm_lo_o <= '0; avg_wm_up_o <= '0; avg_wm_lo_o <= '0; target_o <= '0;
      end else begin
         done_o  <= 1'b0;
         issue_q <= 1'b0;
         unique case (step_q)
            ST_IDLE: if (start_i) begin
               cur_q <= cur_khz_i; max_q <= max_khz_i; avg_q <= avg_i;
               per_q <= COEF_W'(period_ms_i);
               upc_q <= up_coef_i; dnc_q <= dn_coef_i;
               uthr_q <= up_thr_i; dthr_q <= dn_thr_i;
               up_q <= flag_up_i; dn_q <= flag_dn_i;
               issue_q <= 1'b1;
               if (reseed_i) begin
                  boost_o <= '0; en_above_o <= 1'b1; en_below_o <= 1'b0;
                  step_q <= ST_SEED;
               end else if (flag_up_i || flag_dn_i) begin
                  step_q <= ST_BOOST;
               end else begin
                  step_q <= ST_BANDA;
               end
            end
            ST_FIN: begin
               avg_wm_up_o <= avg_sum[FREQ_W] ? FMAX : avg_sum[FREQ_W-1:0];
               avg_wm_lo_o <= (avg_q > band_q) ? avg_q - band_q : '0;
               target_o    <= tgt_sum[FREQ_W] ? FMAX : tgt_sum[FREQ_W-1:0];
               done_o      <= 1'b1;
               step_q      <= ST_IDLE;
            end
            default: if (div_done) begin
               unique case (step_q)
                  ST_SEED:  avg_q <= res;
                  ST_BOOST: begin
                     if (up_q) begin
                        en_below_o <= 1'b1;
                        if (up_sum >= {1'b0, max_q}) begin
                           boost_o <= max_q; en_above_o <= 1'b0;
                        end else begin
                           boost_o <= up_sum[FREQ_W-1:0];
                        end
                     end else begin
                        en_above_o <= 1'b1;
                        if (res < HALFV) begin
                           boost_o <= '0; en_below_o <= 1'b0;
                        end else begin
                           boost_o <= res;
                        end
                     end
                  end
                  ST_BANDA: banda_q <= res;
                  ST_BAND:  band_q  <= res;
                  ST_BASE:  base_q  <= res;
                  ST_WMUP:  wm_up_o <= res;
                  ST_WMLO:  wm_lo_o <= res;
                  ST_T1:    t1_q    <= res;
                  ST_COEF:  coef_q  <= res;
                  default:  tq_q    <= res;
               endcase
               step_q  <= nxt;
               issue_q <= (nxt != ST_FIN);
            end
         endcase
      end
   end
endmodule

// File: rtl/boost_gov_chk.sv
module boost_gov_chk #(
   parameter int FREQ_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [FREQ_W-1:0] boost_o,
   input logic              en_above_o,
   input logic              en_below_o,
   input logic [FREQ_W-1:0] wm_up_o,
   input logic [FREQ_W-1:0] avg_wm_up_o,
   input logic [FREQ_W-1:0] avg_wm_lo_o,
   input logic [FREQ_W-1:0] target_o
);
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R1
   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R1
   AST_ENABLE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_above_o || en_below_o); // R3
   AST_AVG_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> avg_wm_lo_o <= avg_wm_up_o); // R6
   AST_TARGET_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> target_o >= boost_o); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> ($stable(boost_o) && $stable(target_o) && $stable(wm_up_o)
                                 && $stable(en_above_o) && $stable(en_below_o))); // R12
endmodule

bind boost_gov boost_gov_chk #(.FREQ_W(FREQ_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
   .boost_o(boost_o), .en_above_o(en_above_o), .en_below_o(en_below_o), .wm_up_o(wm_up_o),
   .avg_wm_up_o(avg_wm_up_o), .avg_wm_lo_o(avg_wm_lo_o), .target_o(target_o));

// File: tb/sim_boost_gov.sv
module sim_boost_gov;
   localparam longint unsigned M32 = 64'hFFFF_FFFF;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start = 1'b0, reseed = 1'b0, fup = 1'b0, fdn = 1'b0;
   logic [31:0] avg = '0, cur = '0, mx = '0;
   logic [8:0]  per = 9'd1;
   logic [15:0] upc = '0, dnc = '0, uthr = 16'd1, dthr = '0;
   logic        busy, done, ea, eb;
   logic [31:0] boost, wmu, wml, awu, awl, tgt;

   int checks = 0, fails = 0;
   longint unsigned m_boost = 0;
   bit m_ea = 1'b1, m_eb = 1'b0;

   always #2 clk = ~clk;

   boost_gov u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reseed_i(reseed),
      .flag_up_i(fup), .flag_dn_i(fdn), .avg_i(avg), .cur_khz_i(cur), .max_khz_i(mx),
      .period_ms_i(per), .up_coef_i(upc), .dn_coef_i(dnc), .up_thr_i(uthr), .dn_thr_i(dthr),
      .busy_o(busy), .done_o(done), .boost_o(boost), .en_above_o(ea), .en_below_o(eb),
      .wm_up_o(wmu), .wm_lo_o(wml), .avg_wm_up_o(awu), .avg_wm_lo_o(awl), .target_o(tgt));

   function automatic longint unsigned sat(input longint unsigned v);
      return (v > M32) ? M32 : v;
   endfunction

   function automatic longint unsigned pct(input longint unsigned v, input longint unsigned p);
      return sat(v * p / 100);
   endfunction

   task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run(input bit rs, input bit fu, input bit fd, input logic [31:0] a_in,
                      input logic [31:0] c_in, input logic [31:0] m_in, input logic [8:0] p_in,
                      input logic [15:0] uc, input logic [15:0] dc, input logic [15:0] ut,
                      input logic [15:0] dt, input bit poke);
      longint unsigned a, s, band, base, t1, cf, tq, e_awu, e_awl, e_tgt;
      string btag;
      btag = rs ? "R9" : (fu ? (fd ? "R4" : "R2") : (fd ? "R3" : "R11"));
      a = rs ? sat(longint'(c_in) * p_in) : longint'(a_in);
      if (rs) begin
         m_boost = 0; m_ea = 1'b1; m_eb = 1'b0;
      end else if (fu) begin
         s = pct(m_boost, uc) + 16000;
         m_eb = 1'b1;
         if (s >= m_in) begin m_boost = m_in; m_ea = 1'b0; end
         else m_boost = s;
      end else if (fd) begin
         s = pct(m_boost, dc);
         m_ea = 1'b1;
         if (s < 8000) begin m_boost = 0; m_eb = 1'b0; end
         else m_boost = s;
      end
      band  = sat((longint'(m_in) * 6 / 1000) * p_in);
      e_awu = sat(a + band);
      e_awl = (a > band) ? a - band : 0;
      base  = sat(longint'(c_in) * p_in);
      t1    = a / p_in;
      cf    = 10000 / ut;
      tq    = pct(t1, cf);
      e_tgt = sat(tq + m_boost);

      @(negedge clk);
      reseed = rs; fup = fu; fdn = fd; avg = a_in; cur = c_in; mx = m_in; per = p_in;
      upc = uc; dnc = dc; uthr = ut; dthr = dt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy after start", busy, 1);
      if (poke) begin
         repeat (5) @(negedge clk);
         reseed = 1'b1; fup = 1'b1; fdn = 1'b1; avg = $urandom; cur = $urandom;
         mx = $urandom; per = 9'd3; uthr = 16'd7; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk({btag, " boost"}, boost, m_boost);
      chk({btag, " en_above"}, ea, m_ea);
      chk({btag, " en_below"}, eb, m_eb);
      chk("R6 avg_wm_up", awu, e_awu);
      chk("R6 avg_wm_lo", awl, e_awl);
      chk("R7 R5 wm_up", wmu, pct(base, ut));
      chk("R7 R5 wm_lo", wml, pct(base, dt));
      chk("R8 target", tgt, e_tgt);
      chk("R1 done idle", busy, 0);
      @(negedge clk);
      chk("R1 done single", done, 0);
      repeat (3) @(negedge clk);
      chk("R12 idle hold", tgt, e_tgt);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'h5EED_0B57);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 busy", busy, 0);
      chk("R10 done", done, 0);
      chk("R10 boost", boost, 0);
      chk("R10 en_above", ea, 1);
      chk("R10 en_below", eb, 0);
      chk("R10 target", tgt, 0);
      chk("R10 wm_up", wmu, 0);
      // R9 reseed
      run(1, 1, 0, 32'd123, 32'd400000, 32'd800000, 9'd12, 16'd200, 16'd50, 16'd60, 16'd40, 0);
      // R2 growth up to clamp at max
      for (int i = 0; i < 8; i++)
         run(0, 1, 0, 32'd3000000, 32'd400000, 32'd800000, 9'd12, 16'd200, 16'd50, 16'd60, 16'd40, 0);
      // R3 decay to zero cutoff
      for (int i = 0; i < 10; i++)
         run(0, 0, 1, 32'd100000, 32'd400000, 32'd800000, 9'd12, 16'd200, 16'd50, 16'd60, 16'd40, 0);
      // R4 both flags, R11 no flags
      run(0, 1, 1, 32'd5000, 32'd204000, 32'd933000, 9'd20, 16'd800, 16'd40, 16'd27, 16'd10, 0);
      run(0, 0, 0, 32'd5000, 32'd204000, 32'd933000, 9'd20, 16'd800, 16'd40, 16'd27, 16'd10, 0);
      // R5 saturation, R6 cap and floor
      run(0, 1, 0, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd256, 16'd800, 16'd40, 16'd800, 16'd150, 0);
      run(0, 0, 0, 32'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd256, 16'hFFFF, 16'hFFFF, 16'd1, 16'hFFFF, 0);
      // R1 start ignored while busy
      run(0, 0, 1, 32'd77777, 32'd300000, 32'd600000, 9'd16, 16'd200, 16'd50, 16'd20, 16'd10, 1);
      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [8:0] rp;
         logic [15:0] rt;
         rp = 9'(($urandom % 256) + 1);
         rt = 16'(($urandom % 100) + 1);
         run(($urandom % 8) == 0, $urandom % 2, $urandom % 2, $urandom, $urandom % 2000000,
             ($urandom % 2000000) + 1, rp, 16'($urandom % 1000), 16'($urandom % 100), rt,
             16'($urandom % 100), ($urandom % 6) == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule